// File: doc/BRIEF.md
# Timer Channel Register Port

This block is the byte-wide programming and readback front end for a group of up to three 16-bit timer channels. A host writes control words and count bytes over an 8-bit bus with a 2-bit address; the block turns them into per-channel configuration (operating mode, BCD select) and 16-bit initial-count load pulses for the counter channels, which sit outside this block.

On the read side it returns the live count of a channel one byte at a time, or a snapshot captured by a counter-latch or read-back command. A read-back command can also capture a status byte that reports the channel's output level, its null-count flag and its programming. Each channel keeps separate low/high byte toggles for writes and for reads, so an interleaved write and read sequence in word mode stays consistent.

Read data is combinational from the address and the current state; a read strobe sampled at a rising clock edge advances the read sequencing. A data write is captured at the edge, and the resulting load pulse appears for exactly one cycle after that edge.

Top module: `tmr_rw_port`

## Requirements
- R1: A write to address 3 whose bits 7:6 name a channel (0 to 2) and whose bits 5:4 are nonzero programs that channel: bits 5:4 become its access code, bits 3:1 its operating mode (codes 6 and 7 are stored as 2 and 3), bit 0 its BCD flag; `ch_mode` and `ch_bcd` show the stored values.
- R2: With access code 1 (low byte only), a data write to a channel's address pulses that channel's `ld_stb` bit for one cycle after the write edge with `ld_val` equal to {8'h00, byte}; no other channel pulses.
- R3: With access code 2 (high byte only), a data write loads {byte, 8'h00}.
- R4: With access code 3 (word), the first data write produces no load pulse and is held; the second loads {second byte, first byte}.
- R5: Programming a channel with a nonzero access code returns both its write toggle and its read toggle to the low byte.
- R6: A control word with bits 5:4 equal to 0 latches the selected channel's live count and leaves its access code, mode and BCD flag unchanged.
- R7: While a latched count is unread, further count-latch requests for that channel are ignored; the latch is released after one byte read for access codes 1 and 2 (low or high byte respectively) and after two reads (low then high) for code 3, after which reads return the live count.
- R8: Bits 7:6 equal to 3 form a read-back command: bits 1, 2, 3 select channels 0, 1, 2; bit 5 low latches the count and bit 4 low latches the status of each selected channel; unselected channels are untouched.
- R9: The status byte holds the channel's OUT in bit 7, null-count in bit 6, access code in bits 5:4, stored mode in bits 3:1 and BCD in bit 0; a pending status is not overwritten by a later status latch.
- R10: When both status and count are latched, the first read returns the status and subsequent reads return the latched count bytes.
- R11: Without a latch, word-mode reads alternate low byte then high byte of the live count, and this read toggle is independent of the write toggle.
- R12: A read at address 3 returns 8'h00 and changes no channel state.
- R13: After reset every channel has access code 3, mode 0, BCD 0, both toggles on the low byte, no latched count or status, and no load pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | 0 to 2 select a channel data port, 3 the control word |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, advances read sequencing at the rising edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for the addressed port |
| ch_count | input | 48 | Live 16-bit count per channel, channel 0 in the low bits |
| ch_out | input | 3 | OUT level per channel |
| ch_null | input | 3 | Null-count flag per channel |
| ld_stb | output | 3 | One-cycle initial-count load pulse per channel |
| ld_val | output | 48 | Initial count per channel, valid with its pulse |
| ch_mode | output | 9 | Stored 3-bit operating mode per channel |
| ch_bcd | output | 3 | Stored BCD flag per channel |

## Verification
A wrong toggle or latch state shows at the ports on the very next data read or write of that channel: a byte from the wrong half, a missing or premature load pulse, or a live value where a frozen snapshot was expected. Bad programming shows in the status byte returned by a read-back one read after the command. The bench therefore follows every command with the exact read or write sequence that exposes its state, using directed cases for toggle interleaving, ignored latches and status priority, and a seeded random sweep over channels, access codes, modes and data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Access code held per channel; the zero code doubles as "no latch pending".
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2,
      ACC_WORD = 2'd3
   } acc_e;

   typedef struct packed {
      logic       out;
      logic       nul;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } stat_t;

   // Mode codes 6 and 7 alias onto 2 and 3.
   function automatic logic [2:0] fold_mode(input logic [2:0] m);
      return (m > 3'd5) ? (m - 3'd4) : m;
   endfunction

endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode #(
   parameter int NUM_CH = 3
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [7:1]        wbits,
   output logic [NUM_CH-1:0] cfg_we,
   output logic [NUM_CH-1:0] cnt_lat,
   output logic [NUM_CH-1:0] sts_lat,
   output logic [NUM_CH-1:0] dat_we,
   output logic [NUM_CH-1:0] dat_re
);
   localparam logic [1:0] CW_ADDR = 2'd3;
   localparam logic [1:0] RB_SEL  = 2'd3;

   logic       cw_wr;
   logic [1:0] sel;
   logic       is_rb;
   logic       acc_zero;

   assign cw_wr    = wr_en && (addr == CW_ADDR);
   assign sel      = wbits[7:6];
   assign is_rb    = (sel == RB_SEL);
   assign acc_zero = (wbits[5:4] == 2'd0);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      logic hit_sel;
      logic hit_rb;
      assign hit_sel   = cw_wr && !is_rb && (sel == 2'(i));
      assign hit_rb    = cw_wr && is_rb && wbits[1+i];
      assign cfg_we[i]  = hit_sel && !acc_zero;
      assign cnt_lat[i] = (hit_sel && acc_zero) || (hit_rb && !wbits[5]);
      assign sts_lat[i] = hit_rb && !wbits[4];
      assign dat_we[i]  = wr_en && (addr == 2'(i));
      assign dat_re[i]  = rd_en && (addr == 2'(i));
   end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
   import tmr_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [5:0]          cfg_bits,
   input  logic                cnt_lat,
   input  logic                sts_lat,
   input  logic                dat_we,
   input  logic                dat_re,
   input  logic [BYTE_W-1:0]   wbyte,
   input  logic [2*BYTE_W-1:0] live,
   input  logic                out_i,
   input  logic                null_i,
   output logic [BYTE_W-1:0]   rd_byte,
   output logic                load_stb,
   output logic [2*BYTE_W-1:0] load_val,
   output logic [2:0]          mode_o,
   output logic                bcd_o
);
   localparam int CNT_W = 2 * BYTE_W;

   if (BYTE_W != $bits(stat_t)) begin : g_chk_w
      $error("tmr_chan_port: status byte layout needs BYTE_W of 8");
   end

   acc_e              acc;
   logic [2:0]        mode;
   logic              bcd;
   logic              wr_hi;
   logic              rd_hi;
   logic [BYTE_W-1:0] hold;
   acc_e              lat;
   logic [CNT_W-1:0]  lcnt;
   logic              sts_v;
   stat_t             sts;

   assign mode_o = mode;
   assign bcd_o  = bcd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= ACC_WORD;
         mode     <= '0;
         bcd      <= 1'b0;
         wr_hi    <= 1'b0;
         rd_hi    <= 1'b0;
         hold     <= '0;
         lat      <= ACC_NONE;
         lcnt     <= '0;
         sts_v    <= 1'b0;
         sts      <= '0;
         load_stb <= 1'b0;
         load_val <= '0;
      end else begin
         load_stb <= 1'b0;

         if (cfg_we) begin
            acc   <= acc_e'(cfg_bits[5:4]);
            mode  <= fold_mode(cfg_bits[3:1]);
            bcd   <= cfg_bits[0];
            wr_hi <= 1'b0;
            rd_hi <= 1'b0;
         end

         if (dat_we) begin
            unique case (acc)
               ACC_HI: begin
                  load_val <= {wbyte, {BYTE_W{1'b0}}};
                  load_stb <= 1'b1;
               end
               ACC_WORD: begin
                  if (!wr_hi) begin
                     hold  <= wbyte;
                     wr_hi <= 1'b1;
                  end else begin
                     load_val <= {wbyte, hold};
                     load_stb <= 1'b1;
                     wr_hi    <= 1'b0;
                  end
               end
               default: begin
                  load_val <= {{BYTE_W{1'b0}}, wbyte};
                  load_stb <= 1'b1;
               end
            endcase
         end

         if (dat_re) begin
            if (sts_v) begin
               sts_v <= 1'b0;
            end else if (lat != ACC_NONE) begin
               lat <= (lat == ACC_WORD) ? ACC_HI : ACC_NONE;
            end else if (acc == ACC_WORD) begin
               rd_hi <= ~rd_hi;
            end
         end

         if (cnt_lat && (lat == ACC_NONE)) begin
            lcnt <= live;
            lat  <= acc;
         end

         if (sts_lat && !sts_v) begin
            sts   <= '{out: out_i, nul: null_i, acc: acc, mode: mode, bcd: bcd};
            sts_v <= 1'b1;
         end
      end
   end

   always_comb begin
      if (sts_v) begin
         rd_byte = sts;
      end else if (lat == ACC_LO || lat == ACC_WORD) begin
         rd_byte = lcnt[BYTE_W-1:0];
      end else if (lat == ACC_HI) begin
         rd_byte = lcnt[CNT_W-1:BYTE_W];
      end else if (acc == ACC_HI || (acc == ACC_WORD && rd_hi)) begin
         rd_byte = live[CNT_W-1:BYTE_W];
      end else begin
         rd_byte = live[BYTE_W-1:0];
      end
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lat != ACC_NONE && !dat_re) |=> ($stable(lcnt) && $stable(lat))); // R7
   AST_STS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_v && dat_re && !cnt_lat) |=> $stable(lat)); // R10
   AST_CFG_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !dat_we && !dat_re) |=> (!wr_hi && !rd_hi)); // R5
   AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && acc == ACC_HI) |=> (load_stb && load_val[BYTE_W-1:0] == '0)); // R3
   AST_WORD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && acc == ACC_WORD && !wr_hi) |=> !load_stb); // R4

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic [1:0]               addr,
   input  logic [NUM_CH*BYTE_W-1:0] bytes_i,
   output logic [BYTE_W-1:0]        rdata
);
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == 2'(i)) rdata = bytes_i[i*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/tmr_rw_port.sv
module tmr_rw_port #(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 bus_addr,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [7:0]                 bus_wdata,
   output logic [7:0]                 bus_rdata,
   input  logic [NUM_CH*2*BYTE_W-1:0] ch_count,
   input  logic [NUM_CH-1:0]          ch_out,
   input  logic [NUM_CH-1:0]          ch_null,
   output logic [NUM_CH-1:0]          ld_stb,
   output logic [NUM_CH*2*BYTE_W-1:0] ld_val,
   output logic [NUM_CH*3-1:0]        ch_mode,
   output logic [NUM_CH-1:0]          ch_bcd
);
   localparam int CNT_W = 2 * BYTE_W;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_chk_n
      $error("tmr_rw_port: NUM_CH must be 1 to 3");
   end
   if (BYTE_W != 8) begin : g_chk_b
      $error("tmr_rw_port: BYTE_W must be 8");
   end

   logic [NUM_CH-1:0]        cfg_we, cnt_lat, sts_lat, dat_we, dat_re;
   logic [NUM_CH*BYTE_W-1:0] rd_bytes;

   tmr_cw_decode #(.NUM_CH(NUM_CH)) u_dec (
      .wr_en   (bus_wr),
      .rd_en   (bus_rd),
      .addr    (bus_addr),
      .wbits   (bus_wdata[7:1]),
      .cfg_we  (cfg_we),
      .cnt_lat (cnt_lat),
      .sts_lat (sts_lat),
      .dat_we  (dat_we),
      .dat_re  (dat_re)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_chan_port #(.BYTE_W(BYTE_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we[i]),
         .cfg_bits (bus_wdata[5:0]),
         .cnt_lat  (cnt_lat[i]),
         .sts_lat  (sts_lat[i]),
         .dat_we   (dat_we[i]),
         .dat_re   (dat_re[i]),
         .wbyte    (bus_wdata),
         .live     (ch_count[i*CNT_W +: CNT_W]),
         .out_i    (ch_out[i]),
         .null_i   (ch_null[i]),
         .rd_byte  (rd_bytes[i*BYTE_W +: BYTE_W]),
         .load_stb (ld_stb[i]),
         .load_val (ld_val[i*CNT_W +: CNT_W]),
         .mode_o   (ch_mode[i*3 +: 3]),
         .bcd_o    (ch_bcd[i])
      );
   end

   tmr_rd_mux #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_mux (
      .addr    (bus_addr),
      .bytes_i (rd_bytes),
      .rdata   (bus_rdata)
   );

   AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_stb)); // R2
   AST_CW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd3) |-> (bus_rdata == 8'h00)); // R12
   AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'd0 && bus_wdata[5:4] != 2'd0)
      |=> (ch_mode[2:0] <= 3'd5)); // R1

endmodule

// File: tb/tb_tmr_rw_port.sv
module tb_tmr_rw_port;
   localparam int N = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] ch_count = '0;
   logic [2:0]  ch_out = '0;
   logic [2:0]  ch_null = '0;
   logic [2:0]  ld_stb;
   logic [47:0] ld_val;
   logic [8:0]  ch_mode;
   logic [2:0]  ch_bcd;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tmr_rw_port #(.NUM_CH(N), .BYTE_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ch_count(ch_count), .ch_out(ch_out), .ch_null(ch_null),
      .ld_stb(ld_stb), .ld_val(ld_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rdchk(input logic [1:0] a, input logic [7:0] exp, input string req);
      logic [7:0] v;
      rd(a, v);
      chk(req, int'(v), int'(exp));
   endtask

   function automatic logic [2:0] fold(input logic [2:0] m);
      return (m >= 3'd6) ? m - 3'd4 : m;
   endfunction

   function automatic logic [15:0] exp_load(input logic [1:0] acc, input logic [7:0] b0,
                                            input logic [7:0] b1);
      case (acc)
         2'd1:    return {8'h00, b0};
         2'd2:    return {b0, 8'h00};
         default: return {b1, b0};
      endcase
   endfunction

   function automatic logic [7:0] exp_stat(input logic o, input logic nl, input logic [1:0] acc,
                                           input logic [2:0] m, input logic b);
      return {o, nl, acc, fold(m), b};
   endfunction

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 reset state
      chk("R13 ld_stb", int'(ld_stb), 0);
      chk("R13 mode", int'(ch_mode), 0);
      chk("R13 bcd", int'(ch_bcd), 0);
      ch_out = 3'b001; ch_null = 3'b000;
      wr(3, 8'hE2);
      rdchk(0, 8'hB0, "R13 status after reset");

      // R1 / R9 programming with mode alias
      ch_null = 3'b010;
      wr(3, 8'h5F);
      chk("R1 mode ch1", int'(ch_mode[5:3]), 3);
      chk("R1 bcd ch1", int'(ch_bcd[1]), 1);
      wr(3, 8'hE4);
      rdchk(1, 8'h57, "R9 status layout ch1");

      // R2 low byte only
      wr(1, 8'hA5);
      chk("R2 stb", int'(ld_stb), 3'b010);
      chk("R2 val", int'(ld_val[31:16]), 16'h00A5);

      // R3 high byte only
      wr(3, 8'hA0);
      wr(2, 8'h3C);
      chk("R3 stb", int'(ld_stb), 3'b100);
      chk("R3 val", int'(ld_val[47:32]), 16'h3C00);

      // R4 word load on ch0
      wr(0, 8'h34);
      chk("R4 no load after first", int'(ld_stb), 0);
      wr(0, 8'h12);
      chk("R4 stb", int'(ld_stb), 3'b001);
      chk("R4 val", int'(ld_val[15:0]), 16'h1234);

      // R5 toggles reset by programming
      wr(0, 8'h77);
      wr(3, 8'h34);
      wr(0, 8'h11);
      chk("R5 write toggle reset", int'(ld_stb), 0);
      wr(0, 8'h22);
      chk("R5 val", int'(ld_val[15:0]), 16'h2211);
      ch_count[15:0] = 16'hBEEF;
      rdchk(0, 8'hEF, "R11 first lo");
      wr(3, 8'h34);
      rdchk(0, 8'hEF, "R5 read toggle reset");

      // R11 alternation independent of write toggle
      rdchk(0, 8'hBE, "R11 hi");
      wr(0, 8'h55);
      rdchk(0, 8'hEF, "R11 lo after write");
      wr(0, 8'h66);
      chk("R11 load", int'(ld_val[15:0]), 16'h6655);
      rdchk(0, 8'hBE, "R11 hi after load");

      // R6 counter latch keeps programming
      ch_count[15:0] = 16'h1357;
      wr(3, 8'h00);
      ch_count[15:0] = 16'h9999;
      rdchk(0, 8'h57, "R6 latched lo");
      rdchk(0, 8'h13, "R6 latched hi");
      rdchk(0, 8'h99, "R6 live after release");
      ch_null = 3'b000;
      wr(3, 8'hE2);
      rdchk(0, 8'hB4, "R6 programming kept");

      // R7 ignored relatch, release rules
      ch_count[15:0] = 16'h1357;
      wr(3, 8'h00);
      ch_count[15:0] = 16'h2468;
      wr(3, 8'h00);
      rdchk(0, 8'h57, "R7 first latch lo");
      rdchk(0, 8'h13, "R7 first latch hi");
      wr(3, 8'h00);
      rdchk(0, 8'h68, "R7 new latch lo");
      rdchk(0, 8'h24, "R7 new latch hi");
      ch_count[31:16] = 16'hABCD;
      wr(3, 8'h40);
      ch_count[31:16] = 16'h0000;
      rdchk(1, 8'hCD, "R7 lo-only latch");
      rdchk(1, 8'h00, "R7 lo-only released");

      // R8 read-back count on ch0 and ch2
      ch_count = {16'hC3C4, 16'h1111, 16'h0A0B};
      wr(3, 8'hDA);
      ch_count = '0;
      rdchk(0, 8'h0B, "R8 ch0 lo");
      rdchk(0, 8'h0A, "R8 ch0 hi");
      rdchk(2, 8'hC3, "R8 ch2 hi-only");
      rdchk(2, 8'h00, "R8 ch2 released");
      rdchk(1, 8'h00, "R8 ch1 not selected");

      // R10 status before count
      ch_count[31:16] = 16'h7788;
      ch_out = 3'b010;
      wr(3, 8'hC4);
      ch_count[31:16] = 16'h0001;
      rdchk(1, 8'h97, "R10 status first");
      rdchk(1, 8'h88, "R10 count next");
      rdchk(1, 8'h01, "R10 live after");

      // R12 control address read
      wr(3, 8'h34);
      ch_count[15:0] = 16'h4321;
      rdchk(3, 8'h00, "R12 zero");
      rdchk(3, 8'h00, "R12 zero again");
      rdchk(0, 8'h21, "R12 no state change");

      // Random sweep: R1 R2 R3 R4 R7 R9
      for (int it = 0; it < 60; it++) begin
         logic [1:0]  c;
         logic [1:0]  acc;
         logic [2:0]  m;
         logic        b;
         logic [7:0]  b0, b1;
         logic [15:0] lv;
         c   = 2'($urandom % 3);
         acc = 2'(1 + $urandom % 3);
         m   = 3'($urandom);
         b   = 1'($urandom);
         b0  = 8'($urandom);
         b1  = 8'($urandom);
         wr(3, {c, acc, m, b});
         chk("R1 rand mode", int'(ch_mode[c*3 +: 3]), int'(fold(m)));
         wr(c, b0);
         if (acc == 2'd3) begin
            chk("R4 rand first", int'(ld_stb), 0);
            wr(c, b1);
         end
         chk("R2 rand stb", int'(ld_stb), 1 << c);
         chk("R3 rand val", int'(ld_val[c*16 +: 16]), int'(exp_load(acc, b0, b1)));
         lv = 16'($urandom);
         ch_count[c*16 +: 16] = lv;
         wr(3, {c, 6'b00_0000});
         ch_count[c*16 +: 16] = 16'($urandom);
         if (acc == 2'd1) rdchk(c, lv[7:0], "R7 rand lo");
         else if (acc == 2'd2) rdchk(c, lv[15:8], "R7 rand hi");
         else begin
            rdchk(c, lv[7:0], "R7 rand word lo");
            rdchk(c, lv[15:8], "R7 rand word hi");
         end
         ch_out = 3'($urandom);
         ch_null = 3'($urandom);
         wr(3, 8'hE0 | (8'd2 << c));
         rdchk(c, exp_stat(ch_out[c], ch_null[c], acc, m, b), "R9 rand status");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule